// File: doc/BRIEF.md
# Per-Wavefront Victim Tag Detector

This block spots cache lines that a wavefront lost to pressure from other wavefronts. It watches three event streams from a level-one data cache. A fill event records which wavefront reserved a given set and way. An eviction event carries the tag of the line being removed. A miss event carries the tag and the wavefront that requested it. On each eviction, the block looks up the wavefront that originally reserved that set and way. It then files the victim tag in that wavefront's private partition. A partition holds tags only and never line data.

Every miss probes only the partition that belongs to the missing wavefront. A match means the line would have hit if the wavefront had kept more of the cache to itself. The block then reports a one-cycle hit pulse with the wavefront ID, which feeds an issue-throttling score. Each partition replaces its entries in FIFO order. A matched entry is retired so that it reports only once. A kernel launch strobe empties every partition.

All three event inputs are plain strobes with no back-pressure. The upstream cache never stalls on this block, and an event is taken in every cycle its valid bit is high. The hit output is likewise a strobe with no ready signal, because the scoring logic must absorb one event per cycle.

Top module: `lost_locality_detector`

## Requirements
- R1: After reset `hit_valid` is 0 and all partitions are empty, so a miss with any tag produces no hit pulse.
- R2: A fill records `fill_wid` as owner of (`fill_set`, `fill_way`). A later eviction of that set and way files `evict_tag` in that owner's partition.
- R3: A miss probes only the partition of `miss_wid`. A tag held in another wavefront's partition, or a tag that is absent, gives no hit.
- R4: A matching miss sets `hit_valid` high for exactly one cycle, in the cycle after the miss is presented. In that cycle `hit_wid` equals the miss's `miss_wid`.
- R5: A victim hit invalidates the matching entry, so an identical second miss gives no hit.
- R6: Each partition holds `DEPTH` tags. When more tags arrive, the oldest inserted tag is overwritten first, and the newer `DEPTH` tags stay matchable.
- R7: `kernel_start` clears every partition. A miss presented in the same cycle as `kernel_start` gives no hit.
- R8: When an eviction and a miss on the same partition arrive in the same cycle, the probe sees the contents before the insertion. The inserted tag matches from the next miss onward.
- R9: When a fill and an eviction target the same set and way in the same cycle, the eviction uses the owner recorded before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kernel_start | input | 1 | Strobe that empties all partitions |
| fill_valid | input | 1 | Fill event strobe |
| fill_set | input | SET_W | Cache set of the filled line |
| fill_way | input | WAY_W | Cache way of the filled line |
| fill_wid | input | WID_W | Wavefront reserving the line |
| evict_valid | input | 1 | Eviction event strobe |
| evict_set | input | SET_W | Cache set of the victim line |
| evict_way | input | WAY_W | Cache way of the victim line |
| evict_tag | input | TAG_W | Tag of the victim line |
| miss_valid | input | 1 | Miss event strobe |
| miss_wid | input | WID_W | Wavefront that missed |
| miss_tag | input | TAG_W | Tag that missed |
| hit_valid | output | 1 | Victim hit pulse |
| hit_wid | output | WID_W | Wavefront that lost the line |

## Verification
The main function is tried with a miss from a wavefront other than the owner and then a miss from the owner. This separates filing under the reserving wavefront from filing under the prober. A repeat of the matching miss, and an idle cycle after a hit, show retirement of the entry and the single-cycle pulse. A burst of DEPTH+1 evictions into one partition, followed by misses on every tag, shows that FIFO replacement drops exactly the oldest tag. Same-cycle collisions of a fill with an eviction, of an eviction with a miss, and of a kernel launch with a miss show which state each event observes.

// File: rtl/lld_pkg.sv
`timescale 1ns/1ps
package lld_pkg;
  localparam int unsigned DEF_NUM_WF = 4;
  localparam int unsigned DEF_TAG_W  = 20;
  localparam int unsigned DEF_DEPTH  = 4;
  localparam int unsigned DEF_SETS   = 16;
  localparam int unsigned DEF_WAYS   = 4;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lld_owner_table.sv
`timescale 1ns/1ps
module lld_owner_table #(
  parameter int unsigned SETS  = lld_pkg::DEF_SETS,
  parameter int unsigned WAYS  = lld_pkg::DEF_WAYS,
  parameter int unsigned NUM_WF = lld_pkg::DEF_NUM_WF,
  localparam int unsigned SET_W = lld_pkg::idx_w(SETS),
  localparam int unsigned WAY_W = lld_pkg::idx_w(WAYS),
  localparam int unsigned WID_W = lld_pkg::idx_w(NUM_WF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [WID_W-1:0] wr_wid,
  input  logic [SET_W-1:0] rd_set,
  input  logic [WAY_W-1:0] rd_way,
  output logic [WID_W-1:0] rd_wid
);
  logic [WID_W-1:0] owner_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(SETS); s++)
        for (int w = 0; w < int'(WAYS); w++)
          owner_q[s][w] <= '0;
    end else if (wr_en) begin
      owner_q[wr_set][wr_way] <= wr_wid;
    end
  end

  // read sees the owner before any same-cycle write
  assign rd_wid = owner_q[rd_set][rd_way];

  assert_owner_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> owner_q[$past(wr_set)][$past(wr_way)] == $past(wr_wid));
endmodule

// File: rtl/lld_partition.sv
`timescale 1ns/1ps
module lld_partition #(
  parameter int unsigned TAG_W = lld_pkg::DEF_TAG_W,
  parameter int unsigned DEPTH = lld_pkg::DEF_DEPTH,
  localparam int unsigned PTR_W = lld_pkg::idx_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic             probe_en,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             probe_hit
);
  logic [TAG_W-1:0] tags_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] match;
  logic [PTR_W-1:0] wptr_q;
  logic [PTR_W-1:0] wptr_nxt;

  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_cmp
    assign match[i] = vld_q[i] && (tags_q[i] == probe_tag);
  end

  assign probe_hit = probe_en && (|match);
  assign wptr_nxt  = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      wptr_q <= '0;
    end else if (clr) begin
      vld_q  <= '0;
      wptr_q <= '0;
    end else begin
      if (probe_hit) vld_q <= vld_q & ~match;
      if (ins_en) begin
        vld_q[wptr_q] <= 1'b1;   // insertion wins over same-cycle retirement
        wptr_q        <= wptr_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en && !clr) tags_q[wptr_q] <= ins_tag;
  end

  assert_insert_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !clr) |=> (vld_q[$past(wptr_q)] && tags_q[$past(wptr_q)] == $past(ins_tag)));

  assert_match_retired_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_hit && !clr && !ins_en) |=> ((vld_q & $past(match)) == '0));

  assert_clear_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));
endmodule

// File: rtl/lost_locality_detector.sv
`timescale 1ns/1ps
module lost_locality_detector #(
  parameter int unsigned NUM_WF = lld_pkg::DEF_NUM_WF,
  parameter int unsigned TAG_W  = lld_pkg::DEF_TAG_W,
  parameter int unsigned DEPTH  = lld_pkg::DEF_DEPTH,
  parameter int unsigned SETS   = lld_pkg::DEF_SETS,
  parameter int unsigned WAYS   = lld_pkg::DEF_WAYS,
  localparam int unsigned SET_W = lld_pkg::idx_w(SETS),
  localparam int unsigned WAY_W = lld_pkg::idx_w(WAYS),
  localparam int unsigned WID_W = lld_pkg::idx_w(NUM_WF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kernel_start,
  input  logic             fill_valid,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [WID_W-1:0] fill_wid,
  input  logic             evict_valid,
  input  logic [SET_W-1:0] evict_set,
  input  logic [WAY_W-1:0] evict_way,
  input  logic [TAG_W-1:0] evict_tag,
  input  logic             miss_valid,
  input  logic [WID_W-1:0] miss_wid,
  input  logic [TAG_W-1:0] miss_tag,
  output logic             hit_valid,
  output logic [WID_W-1:0] hit_wid
);
  logic [WID_W-1:0]  victim_owner;
  logic [NUM_WF-1:0] part_hit;
  logic              hit_valid_q;
  logic [WID_W-1:0]  hit_wid_q;

  lld_owner_table #(.SETS(SETS), .WAYS(WAYS), .NUM_WF(NUM_WF)) u_owner (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (fill_valid),
    .wr_set (fill_set),
    .wr_way (fill_way),
    .wr_wid (fill_wid),
    .rd_set (evict_set),
    .rd_way (evict_way),
    .rd_wid (victim_owner)
  );

  for (genvar g = 0; g < int'(NUM_WF); g++) begin : g_part
    logic ins_sel;
    logic probe_sel;
    assign ins_sel   = evict_valid && (victim_owner == WID_W'(g));
    assign probe_sel = miss_valid  && (miss_wid == WID_W'(g));

    lld_partition #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_part (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (kernel_start),
      .ins_en    (ins_sel),
      .ins_tag   (evict_tag),
      .probe_en  (probe_sel),
      .probe_tag (miss_tag),
      .probe_hit (part_hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_valid_q <= 1'b0;
      hit_wid_q   <= '0;
    end else begin
      hit_valid_q <= (|part_hit) && !kernel_start;
      hit_wid_q   <= miss_wid;
    end
  end

  assign hit_valid = hit_valid_q;
  assign hit_wid   = hit_wid_q;

  assert_hit_after_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> ($past(miss_valid) && !$past(kernel_start)));

  assert_hit_wid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (hit_wid == $past(miss_wid)));

  assert_launch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kernel_start |=> !hit_valid);
endmodule

// File: tb/lost_locality_detector_bench.sv
`timescale 1ns/1ps
module lost_locality_detector_bench;
  localparam int unsigned NUM_WF = 4;
  localparam int unsigned TAG_W  = 20;
  localparam int unsigned DEPTH  = 4;
  localparam int unsigned SETS   = 16;
  localparam int unsigned WAYS   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kernel_start = 1'b0;
  logic fill_valid = 1'b0;
  logic [3:0] fill_set = '0;
  logic [1:0] fill_way = '0;
  logic [1:0] fill_wid = '0;
  logic evict_valid = 1'b0;
  logic [3:0] evict_set = '0;
  logic [1:0] evict_way = '0;
  logic [TAG_W-1:0] evict_tag = '0;
  logic miss_valid = 1'b0;
  logic [1:0] miss_wid = '0;
  logic [TAG_W-1:0] miss_tag = '0;
  logic hit_valid;
  logic [1:0] hit_wid;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  typedef struct {
    logic       v;
    logic [1:0] w;
    string      req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  lost_locality_detector #(.NUM_WF(NUM_WF), .TAG_W(TAG_W), .DEPTH(DEPTH),
                           .SETS(SETS), .WAYS(WAYS)) u_lost_locality_detector (
    .clk(clk), .rst_n(rst_n), .kernel_start(kernel_start),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way), .fill_wid(fill_wid),
    .evict_valid(evict_valid), .evict_set(evict_set), .evict_way(evict_way), .evict_tag(evict_tag),
    .miss_valid(miss_valid), .miss_wid(miss_wid), .miss_tag(miss_tag),
    .hit_valid(hit_valid), .hit_wid(hit_wid)
  );

  task automatic check(input logic v, input logic [1:0] w, input string req);
    n_checks++;
    if (hit_valid !== v || (v && hit_wid !== w)) begin
      n_fail++;
      $display("FAIL %s: hit_valid=%0b hit_wid=%0d expected hit_valid=%0b hit_wid=%0d",
               req, hit_valid, hit_wid, v, w);
    end
  endtask

  // driver: one cycle of stimulus plus the expected registered result
  task automatic step(input logic fv, input int fs, input int fwy, input int fwid,
                      input logic ev, input int es, input int ewy, input int etag,
                      input logic mv, input int mwid, input int mtag,
                      input logic ks, input logic exp_v, input int exp_w, input string req);
    exp_t e;
    @(negedge clk);
    fill_valid = fv; fill_set = 4'(fs); fill_way = 2'(fwy); fill_wid = 2'(fwid);
    evict_valid = ev; evict_set = 4'(es); evict_way = 2'(ewy); evict_tag = TAG_W'(etag);
    miss_valid = mv; miss_wid = 2'(mwid); miss_tag = TAG_W'(mtag);
    kernel_start = ks;
    e.v = exp_v; e.w = 2'(exp_w); e.req = req;
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic fill(input int s, input int w, input int wid, input string req);
    step(1, s, w, wid, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic evict(input int s, input int w, input int tag, input string req);
    step(0, 0, 0, 0, 1, s, w, tag, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic miss(input int wid, input int tag, input logic ev, input int ew, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, wid, tag, 0, ev, ew, req);
  endtask
  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  // monitor: compares each produced result with the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.v, e.w, e.req);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, 2'd0, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty partitions after reset
    miss(0, 'h5, 0, 0, "R1 miss on empty store");

    // R2 / R3: filed under reserving wavefront, probed only there
    fill(2, 1, 1, "R2 fill");
    evict(2, 1, 'h100, "R2 evict");
    miss(0, 'h100, 0, 0, "R3 other wavefront partition");
    miss(1, 'h999, 0, 0, "R3 absent tag");
    miss(1, 'h100, 1, 1, "R2 owner partition hit");
    idle("R4 single-cycle pulse");
    miss(1, 'h100, 0, 0, "R5 entry retired");

    // R9: same-cycle fill and eviction use prior owner
    fill(4, 0, 2, "R9 first owner");
    step(1, 4, 0, 3, 1, 4, 0, 'h200, 0, 0, 0, 0, 0, 0, "R9 fill and evict together");
    miss(3, 'h200, 0, 0, "R9 new owner lacks tag");
    miss(2, 'h200, 1, 2, "R9 prior owner hit");
    evict(4, 0, 'h201, "R9 evict after refill");
    miss(3, 'h201, 1, 3, "R2 new owner hit wid 3");

    // R6: FIFO replacement with DEPTH+1 tags
    fill(5, 2, 0, "R6 fill");
    for (int i = 0; i <= int'(DEPTH); i++) evict(5, 2, 'h300 + i, "R6 evict");
    miss(0, 'h300, 0, 0, "R6 oldest overwritten");
    for (int i = 1; i <= int'(DEPTH); i++) miss(0, 'h300 + i, 1, 0, "R6 newer retained");

    // R8: eviction and miss in same cycle
    step(0, 0, 0, 0, 1, 5, 2, 'h400, 1, 0, 'h400, 0, 0, 0, "R8 probe before insert");
    miss(0, 'h400, 1, 0, "R8 inserted tag visible");

    // R7: kernel launch clears everything
    evict(5, 2, 'h500, "R7 evict a");
    evict(2, 1, 'h501, "R7 evict b");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 'h500, 1, 0, 0, "R7 miss during launch");
    miss(1, 'h501, 0, 0, "R7 partition cleared");
    miss(0, 'h500, 0, 0, "R7 partition cleared");
    evict(5, 2, 'h502, "R7 evict after launch");
    miss(0, 'h502, 1, 0, "R7 store usable after launch");
    idle("R4 pulse ends");

    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule